// File: doc/BRIEF.md
# Victim Line Buffer with Swap-Back

This block is a small fully associative store of cache lines that a direct-mapped first-level cache has pushed out. Every line the first-level cache discards on a fill is handed to the buffer through the insert port. Each first-level lookup also presents its block address to the buffer in the same cycle. If the buffer holds that block, it reports a hit and returns the line combinationally, so a buffer hit costs no more than a first-level hit.

On a hit the line is exchanged with the first-level cache. The buffered line leaves through the swap-back port toward the first-level arrays. At the following clock edge the line that the first-level cache gives up takes over the entry slot that was hit. Because the exchange reuses that slot, it never sends anything to the next level.

When a new line is inserted while every entry is occupied, the least recently used entry goes out on the writeback port toward the second level in the same cycle, and the new line replaces it at the clock edge. Free entries are always used before any occupied entry is evicted. The recency order is refreshed on every insert and every swap.

Top module: `victim_cache`

## Requirements
- R1: After a synchronous active-low reset no entry is valid, so a lookup of any address reports `lk_hit` = 0.
- R2: A line written through the insert port is found by a later lookup of the same block address, with `lk_hit` = 1 and `lk_data` equal to the inserted data in the same cycle the lookup is presented.
- R3: A lookup of an address that no valid entry holds gives `lk_hit` = 0 and `sb_valid` = 0.
- R4: In a lookup cycle that hits, `sb_valid` = 1, `sb_addr` equals the lookup address and `sb_data` equals the stored line, all in that same cycle.
- R5: After a hit with `lk_disp_valid` = 1, the displaced line (`lk_disp_addr`, `lk_disp_data`) is held by the buffer and the line that was swapped out is no longer held.
- R6: A cycle in which a lookup hits never asserts `wb_valid`.
- R7: An insert while at least one entry is free asserts no `wb_valid`.
- R8: An insert while all entries are valid asserts `wb_valid` in that cycle with the address and data of the least recently used entry, and that line is no longer held afterwards.
- R9: The recency order is updated by both inserts and hits. An entry that was just hit becomes the most recently used one and is evicted last.
- R10: In a cycle where a lookup hits, a simultaneous insert request is ignored: the offered line is not stored.
- R11: A hit with `lk_disp_valid` = 0 frees the hit entry. The next insert fills that entry without any writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | A line evicted from the first-level cache is offered |
| ins_addr | input | ADDR_W | Block address of the offered line |
| ins_data | input | LINE_W | Data of the offered line |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | ADDR_W | Block address being looked up |
| lk_disp_valid | input | 1 | The first-level slot for this lookup holds a valid line that would be displaced |
| lk_disp_addr | input | ADDR_W | Block address of the displaced first-level line |
| lk_disp_data | input | LINE_W | Data of the displaced first-level line |
| lk_hit | output | 1 | The lookup address is held in the buffer |
| lk_data | output | LINE_W | Data of the hit line |
| sb_valid | output | 1 | A line is being returned to the first-level cache |
| sb_addr | output | ADDR_W | Block address of the returned line |
| sb_data | output | LINE_W | Data of the returned line |
| wb_valid | output | 1 | An entry is sent to the second level |
| wb_addr | output | ADDR_W | Block address of the written-back line |
| wb_data | output | LINE_W | Data of the written-back line |

## Verification
The buffer is first filled only up to capacity, which shows that free-slot allocation produces no writeback. It is then overfilled, so that the line written back has to be the oldest one. Swaps are tried with a valid displaced line and with an invalid one, which separates slot reuse from slot release. A hit placed between inserts shows whether hits refresh the recency order, since without that refresh a different line would be evicted. One cycle carries an insert and a hitting lookup together, to show that the swap takes precedence and the offered line is dropped.

// File: rtl/vc_pkg.sv
`timescale 1ns/1ps
// Package: shared definitions for the victim line buffer.
// Assumes nothing beyond being compiled before the modules that import it.
package vc_pkg;
    // Kind of state change the buffer applies at the next clock edge.
    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_INSERT = 2'd1,
        UPD_SWAP   = 2'd2
    } vc_upd_e;
endpackage

// File: rtl/vc_match.sv
`timescale 1ns/1ps
// Module: vc_match
// Compares a lookup address against every entry tag in parallel and encodes
// the matching slot. Assumes no two valid entries ever hold the same tag.
module vc_match #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 26,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             valid_q,
    input  logic [DEPTH-1:0][ADDR_W-1:0] tag_q,
    input  logic [ADDR_W-1:0]            lk_addr,
    output logic [DEPTH-1:0]             hit_vec,
    output logic                         hit_any,
    output logic [IDX_W-1:0]             hit_idx
);
    // One comparator per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_addr);
    end

    assign hit_any = |hit_vec;

    // Encode the matching slot number.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vc_lru.sv
`timescale 1ns/1ps
// Module: vc_lru
// Keeps a full recency ranking of the entries (rank 0 = most recent,
// rank DEPTH-1 = least recent). The ranks always form a permutation.
module vc_lru #(
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] lru_idx
);
    logic [DEPTH-1:0][IDX_W-1:0] rank_q;

    // Move the touched entry to rank 0 and age every entry that was more recent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) rank_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IDX_W'(i) == touch_idx)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    // Find the entry that holds the oldest rank.
    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rank_q[i] == IDX_W'(DEPTH - 1)) lru_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vc_alloc.sv
`timescale 1ns/1ps
// Module: vc_alloc
// Chooses the slot for an insert: the lowest-numbered free entry when one
// exists, otherwise the least recently used entry (which must be evicted).
module vc_alloc #(
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] valid_q,
    input  logic [IDX_W-1:0] lru_idx,
    output logic [IDX_W-1:0] slot_idx,
    output logic             slot_evict
);
    // Priority pick of a free slot, falling back to the oldest entry.
    always_comb begin
        slot_evict = &valid_q;
        slot_idx   = lru_idx;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i]) slot_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/victim_cache.sv
`timescale 1ns/1ps
// Module: victim_cache
// Fully associative buffer of lines evicted from a direct-mapped L1.
// Lookups answer combinationally; a hit swaps the stored line with the
// displaced L1 line in the same slot at the next edge. Inserts fill a free
// slot or push out the least recently used entry on the writeback port.
// Assumes the L1 never offers a line the buffer already holds.
module victim_cache
    import vc_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 26,
    parameter int LINE_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [LINE_W-1:0] ins_data,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_disp_valid,
    input  logic [ADDR_W-1:0] lk_disp_addr,
    input  logic [LINE_W-1:0] lk_disp_data,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_data,
    output logic              sb_valid,
    output logic [ADDR_W-1:0] sb_addr,
    output logic [LINE_W-1:0] sb_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data
);
    logic [DEPTH-1:0]             valid_q;
    logic [DEPTH-1:0][ADDR_W-1:0] tag_q;
    logic [DEPTH-1:0][LINE_W-1:0] data_q;

    logic [DEPTH-1:0] hit_vec;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] lru_idx;
    logic [IDX_W-1:0] slot_idx;
    logic             slot_evict;
    vc_upd_e          upd;
    logic [IDX_W-1:0] upd_idx;

    vc_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) match_i (
        .valid_q (valid_q),
        .tag_q   (tag_q),
        .lk_addr (lk_addr),
        .hit_vec (hit_vec),
        .hit_any (hit_any),
        .hit_idx (hit_idx)
    );

    vc_alloc #(.DEPTH(DEPTH)) alloc_i (
        .valid_q    (valid_q),
        .lru_idx    (lru_idx),
        .slot_idx   (slot_idx),
        .slot_evict (slot_evict)
    );

    vc_lru #(.DEPTH(DEPTH)) lru_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (upd != UPD_NONE),
        .touch_idx (upd_idx),
        .lru_idx   (lru_idx)
    );

    // Decide this cycle's update: a hitting lookup wins over an insert.
    always_comb begin
        upd     = UPD_NONE;
        upd_idx = slot_idx;
        if (lk_valid && hit_any) begin
            upd     = UPD_SWAP;
            upd_idx = hit_idx;
        end else if (ins_valid) begin
            upd = UPD_INSERT;
        end
    end

    // Lookup and swap-back outputs, answered in the lookup cycle.
    always_comb begin
        lk_hit   = lk_valid && hit_any;
        lk_data  = data_q[hit_idx];
        sb_valid = lk_hit;
        sb_addr  = lk_addr;
        sb_data  = data_q[hit_idx];
    end

    // Writeback of the oldest entry when an insert finds the buffer full.
    always_comb begin
        wb_valid = (upd == UPD_INSERT) && slot_evict;
        wb_addr  = tag_q[slot_idx];
        wb_data  = data_q[slot_idx];
    end

    // Valid bits: cleared by reset, set by insert, follow the displaced line on a swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            case (upd)
                UPD_INSERT: valid_q[upd_idx] <= 1'b1;
                UPD_SWAP:   valid_q[upd_idx] <= lk_disp_valid;
                default:    ;
            endcase
        end
    end

    // Tag and data storage, written by insert or swap.
    always_ff @(posedge clk) begin
        case (upd)
            UPD_INSERT: begin
                tag_q[upd_idx]  <= ins_addr;
                data_q[upd_idx] <= ins_data;
            end
            UPD_SWAP: begin
                tag_q[upd_idx]  <= lk_disp_addr;
                data_q[upd_idx] <= lk_disp_data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vc_checker.sv
`timescale 1ns/1ps
// Module: vc_checker
// Property checks for victim_cache, attached through bind below.
module vc_checker #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_hit,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              sb_valid,
    input logic [ADDR_W-1:0] sb_addr,
    input logic              ins_valid,
    input logic              wb_valid,
    input logic [DEPTH-1:0]  hit_vec
);
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit); // R1
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R2
    AST_NO_HIT_WITHOUT_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit && !sb_valid); // R3
    AST_SWAPBACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        sb_valid |-> lk_hit && (sb_addr == lk_addr)); // R4
    AST_SWAP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> !wb_valid); // R6
    AST_WB_NEEDS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ins_valid); // R8
endmodule

bind victim_cache vc_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .lk_addr   (lk_addr),
    .sb_valid  (sb_valid),
    .sb_addr   (sb_addr),
    .ins_valid (ins_valid),
    .wb_valid  (wb_valid),
    .hit_vec   (hit_vec)
);

// File: tb/victim_cache_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for victim_cache, each task checks its own results.
module victim_cache_tb_top;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 26;
    localparam int LINE_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic [LINE_W-1:0] ins_data = '0;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_disp_valid = 1'b0;
    logic [ADDR_W-1:0] lk_disp_addr = '0;
    logic [LINE_W-1:0] lk_disp_data = '0;
    logic              lk_hit;
    logic [LINE_W-1:0] lk_data;
    logic              sb_valid;
    logic [ADDR_W-1:0] sb_addr;
    logic [LINE_W-1:0] sb_data;
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [LINE_W-1:0] wb_data;

    int n_checks = 0;
    int n_fail   = 0;

    victim_cache #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_disp_valid(lk_disp_valid), .lk_disp_addr(lk_disp_addr),
        .lk_disp_data(lk_disp_data),
        .lk_hit(lk_hit), .lk_data(lk_data),
        .sb_valid(sb_valid), .sb_addr(sb_addr), .sb_data(sb_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    always #5 clk = ~clk;

    // Line content derived from its block address.
    function automatic logic [LINE_W-1:0] dat(input logic [ADDR_W-1:0] a);
        return {6'h2A, a, 6'h15, ~a};
    endfunction

    task automatic chk(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check 1 ns later, hold through the rising edge.
    task automatic step(input string req,
                        input logic iv, input logic [ADDR_W-1:0] ia,
                        input logic lv, input logic [ADDR_W-1:0] la,
                        input logic dv, input logic [ADDR_W-1:0] da,
                        input logic exp_hit, input logic exp_wb,
                        input logic [ADDR_W-1:0] exp_wb_addr);
        @(negedge clk);
        ins_valid = iv; ins_addr = ia; ins_data = dat(ia);
        lk_valid = lv; lk_addr = la;
        lk_disp_valid = dv; lk_disp_addr = da; lk_disp_data = dat(da);
        #1;
        chk({req, " lk_hit"}, 64'(lk_hit), 64'(exp_hit && lv));
        chk({req, " sb_valid"}, 64'(sb_valid), 64'(exp_hit && lv));
        if (exp_hit && lv) begin
            chk({req, " lk_data"}, lk_data, dat(la));
            chk({req, " sb_addr"}, 64'(sb_addr), 64'(la));
            chk({req, " sb_data"}, sb_data, dat(la));
        end
        chk({req, " wb_valid"}, 64'(wb_valid), 64'(exp_wb));
        if (exp_wb) begin
            chk({req, " wb_addr"}, 64'(wb_addr), 64'(exp_wb_addr));
            chk({req, " wb_data"}, wb_data, dat(exp_wb_addr));
        end
    endtask

    task automatic ins(input string req, input logic [ADDR_W-1:0] a,
                       input logic exp_wb, input logic [ADDR_W-1:0] wa);
        step(req, 1'b1, a, 1'b0, '0, 1'b0, '0, 1'b0, exp_wb, wa);
    endtask

    task automatic look(input string req, input logic [ADDR_W-1:0] a,
                        input logic dv, input logic [ADDR_W-1:0] da, input logic exp_hit);
        step(req, 1'b0, '0, 1'b1, a, dv, da, exp_hit, 1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ins_valid = 1'b0; lk_valid = 1'b0; lk_disp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill4();
        ins("R7 fill A", 26'h100, 1'b0, '0);
        ins("R7 fill B", 26'h200, 1'b0, '0);
        ins("R7 fill C", 26'h300, 1'b0, '0);
        ins("R7 fill D", 26'h400, 1'b0, '0);
    endtask

    // R1, R3: empty after reset.
    task automatic t_reset();
        do_reset();
        look("R1 after reset", 26'h100, 1'b0, '0, 1'b0);
        look("R3 miss", 26'h3FF, 1'b0, '0, 1'b0);
    endtask

    // R2, R4, R5, R6: hit returns line and swaps with displaced line.
    task automatic t_swap();
        do_reset();
        fill4();
        look("R2 R4 R6 hit C", 26'h300, 1'b1, 26'h500, 1'b1);
        look("R5 C gone", 26'h300, 1'b0, '0, 1'b0);
        look("R5 E held", 26'h500, 1'b1, 26'h300, 1'b1);
        look("R2 C back", 26'h300, 1'b1, 26'h300, 1'b1);
    endtask

    // R8, R9: overflow writes back the oldest entry; hits refresh recency.
    task automatic t_overflow();
        do_reset();
        fill4();
        ins("R8 full insert E", 26'h500, 1'b1, 26'h100);
        look("R8 A gone", 26'h100, 1'b0, '0, 1'b0);
        look("R9 hit B", 26'h200, 1'b1, 26'h200, 1'b1);
        ins("R9 insert F evicts C", 26'h600, 1'b1, 26'h300);
        look("R9 B kept", 26'h200, 1'b1, 26'h200, 1'b1);
    endtask

    // R10: insert ignored in a hitting lookup cycle.
    task automatic t_collide();
        do_reset();
        ins("R10 fill A", 26'h100, 1'b0, '0);
        ins("R10 fill B", 26'h200, 1'b0, '0);
        step("R10 hit+insert", 1'b1, 26'h700, 1'b1, 26'h100, 1'b1, 26'h800, 1'b1, 1'b0, '0);
        look("R10 Y not stored", 26'h700, 1'b0, '0, 1'b0);
        look("R10 X stored", 26'h800, 1'b1, 26'h800, 1'b1);
    endtask

    // R11: hit without displaced line frees the slot.
    task automatic t_release();
        do_reset();
        fill4();
        look("R11 hit B no disp", 26'h200, 1'b0, '0, 1'b1);
        look("R11 B gone", 26'h200, 1'b0, '0, 1'b0);
        ins("R11 insert E uses freed slot", 26'h500, 1'b0, '0);
        ins("R11 insert F evicts A", 26'h600, 1'b1, 26'h100);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_swap();
        t_overflow();
        t_collide();
        t_release();
        @(negedge clk);
        ins_valid = 1'b0; lk_valid = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule